// File: doc/BRIEF.md
# Soft-Decision Frame Loader

This block sits at the front of a quasi-cyclic LDPC decoder. It takes a stream of signed log-likelihood samples, `LANES` samples per clock, framed by start, end and valid qualifiers. It writes each frame into the variable-node buffer. Every write carries a circulant-column index and a slot index inside that circulant, and the slot index counts groups of `LANES` samples. When exactly `BASE_COLS * CIRC_SIZE / LANES` valid beats have arrived and the last one carries end, the block hands the buffer to the decoder core with a one-cycle pulse. It then holds off further input until the core reports that it has consumed the buffer.

A frame that ends too soon is flagged and never handed off. So is a frame whose final expected beat arrives without end. A start seen while the block is not ready drops whatever is in progress and begins a new capture at the first buffer position. The lane count must divide the circulant size. A violating parameter set stops elaboration.

Top module: `llr_frame_loader`

## Requirements
- R1: After reset, `ready` is 1 and `wr_en`, `frame_loaded`, `err_early_end` and `err_no_end` are 0.
- R2: A cycle with `in_valid` low produces no write and does not advance the buffer position.
- R3: A valid beat with `in_start` low that arrives while `ready` is 1 is dropped: no write occurs and `ready` stays 1. This holds even when the beat carries end.
- R4: The k-th valid beat of a frame (k counted from 0) is written one cycle after it is sampled. The write uses `wr_col = k / (CIRC_SIZE/LANES)` and `wr_slot = k % (CIRC_SIZE/LANES)`. `wr_data` equals `in_llr` unchanged, with lane i in bits [i*LLR_W +: LLR_W].
- R5: When beat number TOTAL-1 carries end, `frame_loaded` is 1 for exactly one cycle, in the same cycle as that beat's write. From that cycle on, `ready` is 0.
- R6: After a handed-off frame, `ready` stays 0 until `core_done` is sampled high. It is 1 from the following cycle.
- R7: A valid beat with `in_start` high is always taken as the first beat of a new frame, at column 0 and slot 0. This applies whatever the block is doing, including during a capture or while a loaded frame is held. The abandoned frame raises no pulse.
- R8: If end arrives on a beat before beat TOTAL-1, `err_early_end` pulses for one cycle. This includes end arriving together with start. No hand-off follows, and `ready` is 1 from that cycle.
- R9: If beat TOTAL-1 arrives without end, `err_no_end` pulses for one cycle. No hand-off follows, and `ready` is 1 from that cycle.
- R10: `core_done` has no effect unless a loaded frame is being held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_llr | input | LANES*LLR_W | Signed LLR samples, lane i at bits [i*LLR_W +: LLR_W] |
| in_start | input | 1 | First beat of a frame |
| in_end | input | 1 | Last beat of a frame |
| in_valid | input | 1 | Beat carries data |
| core_done | input | 1 | Decoder core has consumed the buffer |
| ready | output | 1 | Block can accept the start of a new frame |
| wr_en | output | 1 | Buffer write strobe |
| wr_col | output | COL_W | Circulant column of the write |
| wr_slot | output | SLOT_W | Lane-group slot inside the circulant |
| wr_data | output | LANES*LLR_W | Samples to write |
| frame_loaded | output | 1 | One-cycle hand-off pulse to the core |
| err_early_end | output | 1 | One-cycle pulse: end came too soon |
| err_no_end | output | 1 | One-cycle pulse: last beat lacked end |

## Verification
Every write and every pulse is registered, so each appears in the cycle after the rising edge that samples its beat. `ready` is decoded from the state register and changes at that same edge. The bench changes inputs 1 ns after a rising edge. Each beat is therefore sampled at the next edge, and the bench reads the result at the falling edge that follows. A scoreboard queue holds the writes the requirements predict, and the monitor matches them in order against each `wr_en` cycle.

// File: rtl/llr_in_pkg.sv
package llr_in_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_HELD = 2'd2
    } fill_state_t;

    // width of an index that counts 0..n-1, at least one bit
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic bit lanes_fit(input int circ, input int lanes);
        return (lanes > 0) && (circ % lanes == 0);
    endfunction

endpackage

// File: rtl/llr_addr_gen.sv
module llr_addr_gen #(
    parameter int SLOTS  = 4,
    parameter int COLS   = 4,
    parameter int COL_W  = 2,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_one,
    input  logic              adv,
    output logic [COL_W-1:0]  cur_col,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              at_last
);
    localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(COLS - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    assign at_last = (cur_col == LAST_COL) && (cur_slot == LAST_SLOT);

    generate
        if (SLOTS == 1) begin : g_one_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    cur_col <= '0;
                end else if (load_one) begin
                    cur_col <= COL_W'(1);
                end else if (adv) begin
                    cur_col <= cur_col + 1'b1;
                end
            end
            assign cur_slot = '0;
        end else begin : g_multi_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    cur_col  <= '0;
                    cur_slot <= '0;
                end else if (load_one) begin
                    cur_col  <= '0;
                    cur_slot <= SLOT_W'(1);
                end else if (adv) begin
                    if (cur_slot == LAST_SLOT) begin
                        cur_slot <= '0;
                        cur_col  <= cur_col + 1'b1;
                    end else begin
                        cur_slot <= cur_slot + 1'b1;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/llr_frame_fsm.sv
module llr_frame_fsm
    import llr_in_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_start,
    input  logic in_end,
    input  logic in_valid,
    input  logic core_done,
    input  logic at_last,
    output logic is_idle,
    output logic do_write,
    output logic write_zero,
    output logic load_one,
    output logic adv,
    output logic hit_loaded,
    output logic hit_early,
    output logic hit_noend
);
    fill_state_t st, st_nxt;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nxt;
    end

    assign is_idle = (st == ST_IDLE);

    always_comb begin
        st_nxt     = st;
        do_write   = 1'b0;
        write_zero = 1'b0;
        load_one   = 1'b0;
        adv        = 1'b0;
        hit_loaded = 1'b0;
        hit_early  = 1'b0;
        hit_noend  = 1'b0;
        if (in_valid && in_start) begin
            // a start always opens a fresh capture, whatever the state
            do_write   = 1'b1;
            write_zero = 1'b1;
            if (in_end) begin
                hit_early = 1'b1;
                st_nxt    = ST_IDLE;
            end else begin
                load_one = 1'b1;
                st_nxt   = ST_FILL;
            end
        end else if (st == ST_FILL && in_valid) begin
            do_write = 1'b1;
            if (in_end && at_last) begin
                hit_loaded = 1'b1;
                st_nxt     = ST_HELD;
            end else if (in_end) begin
                hit_early = 1'b1;
                st_nxt    = ST_IDLE;
            end else if (at_last) begin
                hit_noend = 1'b1;
                st_nxt    = ST_IDLE;
            end else begin
                adv = 1'b1;
            end
        end else if (st == ST_HELD && core_done) begin
            st_nxt = ST_IDLE;
        end
    end
endmodule

// File: rtl/llr_frame_loader.sv
module llr_frame_loader
    import llr_in_pkg::*;
#(
    parameter  int LLR_W     = 6,
    parameter  int LANES     = 2,
    parameter  int CIRC_SIZE = 8,
    parameter  int BASE_COLS = 4,
    localparam int SLOTS     = CIRC_SIZE / LANES,
    localparam int COL_W     = idx_w(BASE_COLS),
    localparam int SLOT_W    = idx_w(SLOTS),
    localparam int DW        = LANES * LLR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DW-1:0]     in_llr,
    input  logic              in_start,
    input  logic              in_end,
    input  logic              in_valid,
    input  logic              core_done,
    output logic              ready,
    output logic              wr_en,
    output logic [COL_W-1:0]  wr_col,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [DW-1:0]     wr_data,
    output logic              frame_loaded,
    output logic              err_early_end,
    output logic              err_no_end
);
    generate
        if (!lanes_fit(CIRC_SIZE, LANES)) begin : g_bad_lanes
            $error("LANES must divide CIRC_SIZE");
        end
    endgenerate

    logic              is_idle, do_write, write_zero, load_one, adv;
    logic              hit_loaded, hit_early, hit_noend, at_last;
    logic [COL_W-1:0]  cur_col;
    logic [SLOT_W-1:0] cur_slot;

    llr_frame_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .in_start   (in_start),
        .in_end     (in_end),
        .in_valid   (in_valid),
        .core_done  (core_done),
        .at_last    (at_last),
        .is_idle    (is_idle),
        .do_write   (do_write),
        .write_zero (write_zero),
        .load_one   (load_one),
        .adv        (adv),
        .hit_loaded (hit_loaded),
        .hit_early  (hit_early),
        .hit_noend  (hit_noend)
    );

    llr_addr_gen #(
        .SLOTS  (SLOTS),
        .COLS   (BASE_COLS),
        .COL_W  (COL_W),
        .SLOT_W (SLOT_W)
    ) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load_one (load_one),
        .adv      (adv),
        .cur_col  (cur_col),
        .cur_slot (cur_slot),
        .at_last  (at_last)
    );

    assign ready = is_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en         <= 1'b0;
            wr_col        <= '0;
            wr_slot       <= '0;
            frame_loaded  <= 1'b0;
            err_early_end <= 1'b0;
            err_no_end    <= 1'b0;
        end else begin
            wr_en         <= do_write;
            frame_loaded  <= hit_loaded;
            err_early_end <= hit_early;
            err_no_end    <= hit_noend;
            if (do_write) begin
                wr_col  <= write_zero ? '0 : cur_col;
                wr_slot <= write_zero ? '0 : cur_slot;
            end
        end
    end

    // per-lane data capture register
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)           wr_data[i*LLR_W +: LLR_W] <= '0;
            else if (do_write) wr_data[i*LLR_W +: LLR_W] <= in_llr[i*LLR_W +: LLR_W];
        end
    end
endmodule

// File: rtl/llr_frame_loader_chk.sv
module llr_frame_loader_chk #(
    parameter int COL_W  = 2,
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_start,
    input logic              in_end,
    input logic              in_valid,
    input logic              core_done,
    input logic              ready,
    input logic              wr_en,
    input logic [COL_W-1:0]  wr_col,
    input logic [SLOT_W-1:0] wr_slot,
    input logic              frame_loaded,
    input logic              err_early_end,
    input logic              err_no_end
);
    // R2
    no_write_without_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !wr_en);

    // R3
    idle_drops_stray_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && !(in_valid && in_start)) |=> (!wr_en && ready));

    // R5
    loaded_with_write_chk: assert property (@(posedge clk) disable iff (rst)
        frame_loaded |-> (wr_en && !ready));

    // R7
    start_goes_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_start) |=> (wr_en && wr_col == '0 && wr_slot == '0 && !frame_loaded));

    // R8
    early_end_frees_chk: assert property (@(posedge clk) disable iff (rst)
        err_early_end |-> (ready && wr_en));

    // R9
    no_end_frees_chk: assert property (@(posedge clk) disable iff (rst)
        err_no_end |-> (ready && wr_en));

    // R8
    single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_loaded, err_early_end, err_no_end}));

    // R10
    done_ignored_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && core_done && !(in_valid && in_start)) |=> ready);
endmodule

bind llr_frame_loader llr_frame_loader_chk #(
    .COL_W  (COL_W),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_start      (in_start),
    .in_end        (in_end),
    .in_valid      (in_valid),
    .core_done     (core_done),
    .ready         (ready),
    .wr_en         (wr_en),
    .wr_col        (wr_col),
    .wr_slot       (wr_slot),
    .frame_loaded  (frame_loaded),
    .err_early_end (err_early_end),
    .err_no_end    (err_no_end)
);

// File: tb/llr_frame_loader_test.sv
module llr_frame_loader_test;
    localparam int LLR_W = 6, LANES = 2, CIRC_SIZE = 8, BASE_COLS = 4;
    localparam int SLOTS = CIRC_SIZE / LANES;
    localparam int TOTAL = BASE_COLS * SLOTS;
    localparam int COL_W = 2, SLOT_W = 2, DW = LANES * LLR_W;
    localparam int QW = COL_W + SLOT_W + DW;

    logic clk = 0, rst = 1;
    logic [DW-1:0] in_llr = '0;
    logic in_start = 0, in_end = 0, in_valid = 0, core_done = 0;
    logic ready, wr_en, frame_loaded, err_early_end, err_no_end;
    logic [COL_W-1:0] wr_col;
    logic [SLOT_W-1:0] wr_slot;
    logic [DW-1:0] wr_data;

    always #2 clk = ~clk;

    llr_frame_loader #(.LLR_W(LLR_W), .LANES(LANES), .CIRC_SIZE(CIRC_SIZE),
                       .BASE_COLS(BASE_COLS)) uut (
        .clk(clk), .rst(rst), .in_llr(in_llr), .in_start(in_start), .in_end(in_end),
        .in_valid(in_valid), .core_done(core_done), .ready(ready), .wr_en(wr_en),
        .wr_col(wr_col), .wr_slot(wr_slot), .wr_data(wr_data),
        .frame_loaded(frame_loaded), .err_early_end(err_early_end), .err_no_end(err_no_end));

    int tests = 0, fails = 0;
    logic [QW-1:0] expq[$];
    int n_loaded = 0, n_early = 0, n_noend = 0, n_writes = 0;
    int e_loaded = 0, e_early = 0, e_noend = 0, e_writes = 0;
    int mode = 0;   // 0 idle, 1 filling, 2 held
    int pos = 0;
    bit done = 0;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: scoreboard compare of writes, pulse counting
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (wr_en) begin
                n_writes++;
                tests++;
                if (expq.size() == 0) begin
                    fails++;
                    $display("FAIL R4 unexpected write col=%0d slot=%0d actual=1 expected=0", wr_col, wr_slot);
                end else begin
                    logic [QW-1:0] e;
                    e = expq.pop_front();
                    if ({wr_col, wr_slot, wr_data} != e) begin
                        fails++;
                        $display("FAIL R4 write actual=%h expected=%h", {wr_col, wr_slot, wr_data}, e);
                    end
                end
            end
            if (frame_loaded) n_loaded++;
            if (err_early_end) n_early++;
            if (err_no_end) n_noend++;
        end
    end

    function automatic logic [QW-1:0] item(input int p, input logic [DW-1:0] d);
        return {COL_W'(p / SLOTS), SLOT_W'(p % SLOTS), d};
    endfunction

    // driver: one beat per cycle, expected model from the requirements
    task automatic drive(input bit s, input bit e, input bit v, input logic [DW-1:0] d,
                         input bit cd = 0);
        @(posedge clk); #1;
        in_start = s; in_end = e; in_valid = v; in_llr = d; core_done = cd;
        if (v && s) begin
            expq.push_back(item(0, d)); e_writes++;
            if (e) begin e_early++; mode = 0; end
            else begin pos = 1; mode = 1; end
        end else if (v && mode == 1) begin
            expq.push_back(item(pos, d)); e_writes++;
            if (e && pos == TOTAL - 1) begin e_loaded++; mode = 2; end
            else if (e) begin e_early++; mode = 0; end
            else if (pos == TOTAL - 1) begin e_noend++; mode = 0; end
            else pos++;
        end else if (mode == 2 && cd) begin
            mode = 0;
        end
    endtask

    task automatic idle();
        drive(0, 0, 0, '0);
    endtask

    task automatic send_frame(input int n, input bit end_last, input int gap, input int seed);
        for (int k = 0; k < n; k++) begin
            drive(k == 0, end_last && (k == n - 1), 1, DW'(k * 37 + seed * 11 + 5));
            if (gap != 0 && k % gap == 1) idle();
        end
    endtask

    task automatic settle(input string req);
        idle(); idle();
        @(negedge clk);
        check({req, " writes"}, n_writes, e_writes);
        check({req, " loaded"}, n_loaded, e_loaded);
        check({req, " early"}, n_early, e_early);
        check({req, " noend"}, n_noend, e_noend);
        check({req, " ready"}, int'(ready), int'(mode == 0));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1
        check("R1 ready", int'(ready), 1);
        check("R1 wr_en", int'(wr_en), 0);
        check("R1 pulses", int'({frame_loaded, err_early_end, err_no_end}), 0);

        // R3: stray valid beats while idle, one with end
        drive(0, 0, 1, 12'h3a5);
        drive(0, 1, 1, 12'h15c);
        settle("R3");

        // R4 R5: back-to-back full frame, pulse timing at the last write
        send_frame(TOTAL, 1, 0, 1);
        idle();
        @(negedge clk);
        check("R5 loaded pulse", int'(frame_loaded), 1);
        check("R5 ready low", int'(ready), 0);
        idle();
        @(negedge clk);
        check("R5 pulse width", int'(frame_loaded), 0);

        // R6: held until core_done
        repeat (5) idle();
        @(negedge clk);
        check("R6 held", int'(ready), 0);
        drive(0, 0, 0, '0, 1);
        idle();
        @(negedge clk);
        check("R6 released", int'(ready), 1);
        settle("R6");

        // R10: core_done while idle, then a frame with valid gaps (R2)
        drive(0, 0, 0, '0, 1);
        settle("R10");
        send_frame(TOTAL, 1, 3, 2);
        settle("R2");
        drive(0, 0, 0, '0, 1);
        settle("R2 release");

        // R7: abandoned capture then full frame
        send_frame(5, 0, 0, 3);
        send_frame(TOTAL, 1, 0, 4);
        settle("R7 abort fill");
        // R7: start while a loaded frame is held
        send_frame(TOTAL, 1, 0, 5);
        settle("R7 abort held");
        drive(0, 0, 0, '0, 1);
        settle("R7 release");

        // R8: end too soon, and start with end together
        send_frame(7, 1, 0, 6);
        settle("R8 short");
        drive(1, 1, 1, 12'h0f0);
        settle("R8 start_end");

        // R9: last beat without end, then a stray beat that must be dropped
        send_frame(TOTAL, 0, 0, 7);
        drive(0, 1, 1, 12'h777);
        settle("R9");
        check("R9 queue empty", expq.size(), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule